// File: doc/BRIEF.md
# Picture-in-Picture Overlay Generator

This block decides, pixel by pixel, what the display path shows while a small inset picture sits on top of the main picture. It counts pixel clocks from each rising edge of the main horizontal sync and counts lines from the rising edge of the main vertical sync. For every pixel it picks one of five sources: the main picture (switch off), a border frame, a flat fill colour, a blanked inset, or sub-picture samples fetched from an external line buffer. It drives the main/sub switch and 7-bit Y, U and V codes for the output converters.

The inset has two sizes, chosen separately for width and height. Its origin comes from an 8-bit horizontal position in steps of four pixels and an 8-bit vertical position in lines. The line buffer is read with a luma column, a chroma column and an inset line index. It answers one clock later, with one chroma sample for every four luma samples. Blanking and freeze requests take effect only at the next field start. The switch can lag the pixel codes by a programmable number of clocks, to line up with delays further down the path.

Top module: `pip_overlay`

## Requirements
- R1: While reset is held, `pip_sw`, `pip_y`, `pip_u` and `pip_v` read 0 and `sub_cap_en` reads 1.
- R2: A pixel index restarts at 0 on the clock edge where `hd_i` is first sampled high. A line index restarts at 0 on the edge where `vd_i` is first sampled high, and otherwise steps by one on each such `hd_i` edge. The codes for pixel n of a line appear on the outputs after the edge n+3 clocks past the line's restart edge.
- R3: The inset core covers pixels 4*`h_pos` up to 4*`h_pos`+W-1 and lines `v_pos` up to `v_pos`+H-1. W is 229 when `size_h`=0 and 172 when `size_h`=1. H is 69 when `size_v`=0 and 52 when `size_v`=1. The two size bits act independently.
- R4: With `frame_en`=1, a border 2 pixels wide and 2 lines high surrounds the core. It shows Y=`frm_y`*8, U=`frm_u`*16 and V=`frm_v`*16 with the switch on.
- R5: Inside the core, the block shows the line buffer's Y at luma column x-4*`h_pos`, its U and V at chroma column (x-4*`h_pos`)/4, and inset line y-`v_pos`. The buffer returns data one clock after the address.
- R6: With `bg_en`=1, the core shows Y=`bg_y`*8, U=`bg_u`*16 and V=`bg_v`*16. This fill takes priority over blanking.
- R7: A blanked core shows Y=0, U=64 and V=64. `mute_i` is sampled only on the line-index restart edge, so a change in mid-field has no effect until the next field.
- R8: `sub_cap_en` takes the value of `live_i` sampled on the line-index restart edge, and holds it for the rest of the field.
- R9: With `disp_en`=0, `pip_sw` stays 0 and all three codes read 0.
- R10: `pip_sw` for a pixel appears `sw_dly` clocks (0 to 15) after that pixel's codes. The codes themselves are not delayed.
- R11: Outside the core and its border, the codes read 0 and the switch is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hd_i | input | 1 | Main horizontal sync, active high |
| vd_i | input | 1 | Main vertical sync, active high |
| disp_en | input | 1 | Inset shown when 1 |
| size_h | input | 1 | Inset width select: 0 large, 1 small |
| size_v | input | 1 | Inset height select: 0 large, 1 small |
| h_pos | input | 8 | Inset left edge in units of 4 pixels |
| v_pos | input | 8 | Inset top edge in lines |
| frame_en | input | 1 | Border drawn when 1 |
| frm_y | input | 4 | Border luma level |
| frm_u | input | 3 | Border U level |
| frm_v | input | 3 | Border V level |
| bg_en | input | 1 | Flat fill in place of the picture when 1 |
| bg_y | input | 4 | Fill luma level |
| bg_u | input | 3 | Fill U level |
| bg_v | input | 3 | Fill V level |
| live_i | input | 1 | 1 moving inset, 0 still |
| mute_i | input | 1 | Blank the inset when 1 |
| sw_dly | input | 4 | Switch lag in clocks |
| sub_yaddr | output | 8 | Line buffer luma column |
| sub_caddr | output | 6 | Line buffer chroma column |
| sub_line | output | 7 | Inset line index |
| sub_y | input | 7 | Buffer luma sample |
| sub_u | input | 7 | Buffer U sample |
| sub_v | input | 7 | Buffer V sample |
| sub_cap_en | output | 1 | Field capture enable for the sub-picture writer |
| pip_sw | output | 1 | Main/sub switch |
| pip_y | output | 7 | Output luma code |
| pip_u | output | 7 | Output U code |
| pip_v | output | 7 | Output V code |

## Verification
The assertions assume that `hd_i` and `vd_i` are low during reset and on the first clocks after it. The counter and capture checks infer sync edges from the raw inputs, so they rely on this. The switch-lag and display-off checks also assume that `sw_dly` and `disp_en` stay steady over the window they look at. The bench drives both sync pulses low through reset, and it changes configuration only at field starts. The only exceptions are the deliberate mid-field changes of `mute_i` and `live_i`. Inset positions and sizes are drawn at random within ranges that keep the inset, border and switch lag inside a line of 290 clocks.

// File: rtl/pip_pkg.sv
// Shared types for the picture-in-picture overlay.
// Assumes: nothing beyond the SystemVerilog package rules.
package pip_pkg;

    // Source chosen for one pixel
    typedef enum logic [2:0] {
        ZN_MAIN  = 3'd0,
        ZN_EDGE  = 3'd1,
        ZN_FILL  = 3'd2,
        ZN_BLANK = 3'd3,
        ZN_PIC   = 3'd4
    } zone_t;

endpackage

// File: rtl/pip_sync_cnt.sv
// Pixel and line counters driven by the main sync pulses.
// Assumes: hd_i and vd_i are synchronous to clk and high for at least one clock.
module pip_sync_cnt #(
    parameter int HCNT_W = 11,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_i,
    input  logic              vd_i,
    output logic [HCNT_W-1:0] h_cnt,
    output logic [VCNT_W-1:0] v_cnt,
    output logic              vd_rise
);
    logic hd_q, vd_q, hd_rise;

    assign hd_rise = hd_i & ~hd_q;
    assign vd_rise = vd_i & ~vd_q;

    // Remember the previous sync levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q <= 1'b0;
            vd_q <= 1'b0;
        end else begin
            hd_q <= hd_i;
            vd_q <= vd_i;
        end
    end

    // Pixel counter: restart on HD edge, saturate at the top
    always_ff @(posedge clk) begin
        if (!rst_n)                h_cnt <= '0;
        else if (hd_rise)          h_cnt <= '0;
        else if (h_cnt != '1)      h_cnt <= h_cnt + 1'b1;
    end

    // Line counter: restart on VD edge, step on each HD edge
    always_ff @(posedge clk) begin
        if (!rst_n)                       v_cnt <= '0;
        else if (vd_rise)                 v_cnt <= '0;
        else if (hd_rise && v_cnt != '1)  v_cnt <= v_cnt + 1'b1;
    end

endmodule

// File: rtl/pip_window.sv
// Classifies each pixel against the inset window and issues line buffer reads.
// Assumes: configuration is steady within a field; mute and live are
// sampled only at field start. Outputs are registered (one clock).
module pip_window
    import pip_pkg::*;
#(
    parameter int HCNT_W       = 11,
    parameter int VCNT_W       = 10,
    parameter int POS_W        = 8,
    parameter int HPOS_SHIFT   = 2,
    parameter int W_LARGE      = 229,
    parameter int W_SMALL      = 172,
    parameter int H_LARGE      = 69,
    parameter int H_SMALL      = 52,
    parameter int BORDER       = 2,
    parameter int YADDR_W      = 8,
    parameter int CHROMA_SHIFT = 2,
    parameter int LINE_W       = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [HCNT_W-1:0]         h_cnt,
    input  logic [VCNT_W-1:0]         v_cnt,
    input  logic                      vd_rise,
    input  logic                      disp_en,
    input  logic                      size_h,
    input  logic                      size_v,
    input  logic [POS_W-1:0]          h_pos,
    input  logic [POS_W-1:0]          v_pos,
    input  logic                      frame_en,
    input  logic                      bg_en,
    input  logic                      live_i,
    input  logic                      mute_i,
    output zone_t                     zone_q,
    output logic [YADDR_W-1:0]        sub_yaddr,
    output logic [YADDR_W-CHROMA_SHIFT-1:0] sub_caddr,
    output logic [LINE_W-1:0]         sub_line,
    output logic                      sub_cap_en
);
    localparam int XW = HCNT_W + 2;
    localparam int YW = VCNT_W + 2;

    logic [XW-1:0] px, x0, wdt, bx;
    logic [YW-1:0] py, y0, hgt, by;
    logic          core_x, core_y, ext_x, ext_y;
    logic          mute_act, live_act;
    zone_t         zone_d;

    // Window edges and pixel classification
    always_comb begin
        px  = XW'(h_cnt);
        py  = YW'(v_cnt);
        x0  = XW'(h_pos) << HPOS_SHIFT;
        y0  = YW'(v_pos);
        wdt = size_h ? XW'(W_SMALL) : XW'(W_LARGE);
        hgt = size_v ? YW'(H_SMALL) : YW'(H_LARGE);
        bx  = frame_en ? XW'(BORDER) : '0;
        by  = frame_en ? YW'(BORDER) : '0;
        core_x = (px >= x0) && (px < x0 + wdt);
        core_y = (py >= y0) && (py < y0 + hgt);
        ext_x  = (px + bx >= x0) && (px < x0 + wdt + bx);
        ext_y  = (py + by >= y0) && (py < y0 + hgt + by);
        if (!disp_en || !(ext_x && ext_y)) zone_d = ZN_MAIN;
        else if (!(core_x && core_y))      zone_d = ZN_EDGE;
        else if (bg_en)                    zone_d = ZN_FILL;
        else if (mute_act)                 zone_d = ZN_BLANK;
        else                               zone_d = ZN_PIC;
    end

    // Register the zone and the line buffer address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q    <= ZN_MAIN;
            sub_yaddr <= '0;
            sub_line  <= '0;
        end else begin
            zone_q    <= zone_d;
            sub_yaddr <= YADDR_W'(px - x0);
            sub_line  <= LINE_W'(py - y0);
        end
    end

    // Sample mute and freeze requests at field start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_act <= 1'b0;
            live_act <= 1'b1;
        end else if (vd_rise) begin
            mute_act <= mute_i;
            live_act <= live_i;
        end
    end

    assign sub_caddr  = sub_yaddr[YADDR_W-1:CHROMA_SHIFT];
    assign sub_cap_en = live_act;

endmodule

// File: rtl/pip_mixer.sv
// Selects the output codes per zone and delays the switch.
// Assumes: line buffer data arrive one clock after the address, aligned with
// the zone held one stage after pip_window.
module pip_mixer
    import pip_pkg::*;
#(
    parameter int DATA_W  = 7,
    parameter int FILL_YW = 4,
    parameter int FILL_CW = 3,
    parameter int DLY_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  zone_t              zone_in,
    input  logic [DATA_W-1:0]  sub_y,
    input  logic [DATA_W-1:0]  sub_u,
    input  logic [DATA_W-1:0]  sub_v,
    input  logic [FILL_YW-1:0] frm_y,
    input  logic [FILL_CW-1:0] frm_u,
    input  logic [FILL_CW-1:0] frm_v,
    input  logic [FILL_YW-1:0] bg_y,
    input  logic [FILL_CW-1:0] bg_u,
    input  logic [FILL_CW-1:0] bg_v,
    input  logic [DLY_W-1:0]   sw_dly,
    output logic               sw_now,
    output logic               pip_sw,
    output logic [DATA_W-1:0]  pip_y,
    output logic [DATA_W-1:0]  pip_u,
    output logic [DATA_W-1:0]  pip_v
);
    localparam int DLY_N = (1 << DLY_W) - 1;
    localparam logic [DATA_W-1:0] NEUTRAL = DATA_W'(1) << (DATA_W - 1);

    zone_t             z2;
    logic [DLY_N-1:0]  sw_pipe;

    // Align the zone with the returning buffer data
    always_ff @(posedge clk) begin
        if (!rst_n) z2 <= ZN_MAIN;
        else        z2 <= zone_in;
    end

    // Pick the codes for the current pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pip_y  <= '0;
            pip_u  <= '0;
            pip_v  <= '0;
            sw_now <= 1'b0;
        end else begin
            sw_now <= (z2 != ZN_MAIN);
            unique case (z2)
                ZN_EDGE: begin
                    pip_y <= DATA_W'(frm_y) << (DATA_W - FILL_YW);
                    pip_u <= DATA_W'(frm_u) << (DATA_W - FILL_CW);
                    pip_v <= DATA_W'(frm_v) << (DATA_W - FILL_CW);
                end
                ZN_FILL: begin
                    pip_y <= DATA_W'(bg_y) << (DATA_W - FILL_YW);
                    pip_u <= DATA_W'(bg_u) << (DATA_W - FILL_CW);
                    pip_v <= DATA_W'(bg_v) << (DATA_W - FILL_CW);
                end
                ZN_BLANK: begin
                    pip_y <= '0;
                    pip_u <= NEUTRAL;
                    pip_v <= NEUTRAL;
                end
                ZN_PIC: begin
                    pip_y <= sub_y;
                    pip_u <= sub_u;
                    pip_v <= sub_v;
                end
                default: begin
                    pip_y <= '0;
                    pip_u <= '0;
                    pip_v <= '0;
                end
            endcase
        end
    end

    // Switch delay line, one flop per clock of lag
    for (genvar i = 0; i < DLY_N; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n)      sw_pipe[i] <= 1'b0;
            else if (i == 0) sw_pipe[i] <= sw_now;
            else             sw_pipe[i] <= sw_pipe[(i == 0) ? 0 : i - 1];
        end
    end

    assign pip_sw = (sw_dly == '0) ? sw_now : sw_pipe[sw_dly - 1'b1];

endmodule

// File: rtl/pip_overlay.sv
// Top of the picture-in-picture overlay generator.
// Assumes: one clock per output pixel; the line buffer has one clock read latency.
module pip_overlay
    import pip_pkg::*;
#(
    parameter int DATA_W       = 7,
    parameter int HCNT_W       = 11,
    parameter int VCNT_W       = 10,
    parameter int POS_W        = 8,
    parameter int HPOS_SHIFT   = 2,
    parameter int W_LARGE      = 229,
    parameter int W_SMALL      = 172,
    parameter int H_LARGE      = 69,
    parameter int H_SMALL      = 52,
    parameter int BORDER       = 2,
    parameter int CHROMA_SHIFT = 2,
    parameter int FILL_YW      = 4,
    parameter int FILL_CW      = 3,
    parameter int DLY_W        = 4,
    localparam int YADDR_W     = $clog2(W_LARGE),
    localparam int CADDR_W     = YADDR_W - CHROMA_SHIFT,
    localparam int LINE_W      = $clog2(H_LARGE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hd_i,
    input  logic               vd_i,
    input  logic               disp_en,
    input  logic               size_h,
    input  logic               size_v,
    input  logic [POS_W-1:0]   h_pos,
    input  logic [POS_W-1:0]   v_pos,
    input  logic               frame_en,
    input  logic [FILL_YW-1:0] frm_y,
    input  logic [FILL_CW-1:0] frm_u,
    input  logic [FILL_CW-1:0] frm_v,
    input  logic               bg_en,
    input  logic [FILL_YW-1:0] bg_y,
    input  logic [FILL_CW-1:0] bg_u,
    input  logic [FILL_CW-1:0] bg_v,
    input  logic               live_i,
    input  logic               mute_i,
    input  logic [DLY_W-1:0]   sw_dly,
    output logic [YADDR_W-1:0] sub_yaddr,
    output logic [CADDR_W-1:0] sub_caddr,
    output logic [LINE_W-1:0]  sub_line,
    input  logic [DATA_W-1:0]  sub_y,
    input  logic [DATA_W-1:0]  sub_u,
    input  logic [DATA_W-1:0]  sub_v,
    output logic               sub_cap_en,
    output logic               pip_sw,
    output logic [DATA_W-1:0]  pip_y,
    output logic [DATA_W-1:0]  pip_u,
    output logic [DATA_W-1:0]  pip_v
);
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic              vd_rise;
    logic              sw_now;
    zone_t             zone_q;

    pip_sync_cnt #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .vd_rise(vd_rise)
    );

    pip_window #(
        .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .POS_W(POS_W), .HPOS_SHIFT(HPOS_SHIFT),
        .W_LARGE(W_LARGE), .W_SMALL(W_SMALL), .H_LARGE(H_LARGE), .H_SMALL(H_SMALL),
        .BORDER(BORDER), .YADDR_W(YADDR_W), .CHROMA_SHIFT(CHROMA_SHIFT), .LINE_W(LINE_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .vd_rise(vd_rise),
        .disp_en(disp_en), .size_h(size_h), .size_v(size_v),
        .h_pos(h_pos), .v_pos(v_pos), .frame_en(frame_en), .bg_en(bg_en),
        .live_i(live_i), .mute_i(mute_i), .zone_q(zone_q),
        .sub_yaddr(sub_yaddr), .sub_caddr(sub_caddr), .sub_line(sub_line),
        .sub_cap_en(sub_cap_en)
    );

    pip_mixer #(
        .DATA_W(DATA_W), .FILL_YW(FILL_YW), .FILL_CW(FILL_CW), .DLY_W(DLY_W)
    ) u_mix (
        .clk(clk), .rst_n(rst_n), .zone_in(zone_q),
        .sub_y(sub_y), .sub_u(sub_u), .sub_v(sub_v),
        .frm_y(frm_y), .frm_u(frm_u), .frm_v(frm_v),
        .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
        .sw_dly(sw_dly), .sw_now(sw_now), .pip_sw(pip_sw),
        .pip_y(pip_y), .pip_u(pip_u), .pip_v(pip_v)
    );

endmodule

// File: rtl/pip_overlay_chk.sv
// Checker for pip_overlay, attached by bind.
// Assumes: hd_i and vd_i are low during reset.
module pip_overlay_chk #(
    parameter int DATA_W = 7,
    parameter int HCNT_W = 11,
    parameter int VCNT_W = 10,
    parameter int DLY_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hd_i,
    input logic              vd_i,
    input logic              disp_en,
    input logic [DLY_W-1:0]  sw_dly,
    input logic              pip_sw,
    input logic [DATA_W-1:0] pip_y,
    input logic [DATA_W-1:0] pip_u,
    input logic [DATA_W-1:0] pip_v,
    input logic              sub_cap_en,
    input logic [HCNT_W-1:0] h_cnt,
    input logic [VCNT_W-1:0] v_cnt,
    input logic              sw_now
);
    logic [2:0] age;
    logic       warm;

    // Count clocks since reset so $past never reaches before it
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 3'd7) age <= age + 1'b1;
    end
    assign warm = (age == 3'd7);

    AST_HCNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hd_i) && !$past(hd_i, 2)) |-> (h_cnt == '0)); // R2

    AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hd_i) && !$past(hd_i, 2) && !($past(vd_i) && !$past(vd_i, 2))
         && ($past(v_cnt) != '1)) |-> (v_cnt == $past(v_cnt) + 1'b1)); // R2

    AST_CAP_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$stable(sub_cap_en)) |-> ($past(vd_i) && !$past(vd_i, 2))); // R8

    AST_OFF_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !disp_en && !$past(disp_en) && !$past(disp_en, 2) && !$past(disp_en, 3)
         && !$past(disp_en, 4) && sw_dly == '0) |-> !pip_sw); // R9

    AST_SW_LAG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && sw_dly == DLY_W'(1) && $past(sw_dly) == DLY_W'(1)) |-> (pip_sw == $past(sw_now))); // R10

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pip_sw && sw_dly == '0) |-> (pip_y == '0 && pip_u == '0 && pip_v == '0)); // R11

endmodule

bind pip_overlay pip_overlay_chk #(
    .DATA_W(DATA_W), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .DLY_W(DLY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .disp_en(disp_en),
    .sw_dly(sw_dly), .pip_sw(pip_sw), .pip_y(pip_y), .pip_u(pip_u), .pip_v(pip_v),
    .sub_cap_en(sub_cap_en), .h_cnt(h_cnt), .v_cnt(v_cnt), .sw_now(sw_now)
);

// File: tb/sim_pip_overlay.sv
// Bench for pip_overlay: directed fields, then random fields from a fixed seed.
module sim_pip_overlay;
    localparam int CLK_NS = 10;
    localparam int LINE_LEN = 290;
    localparam int HD_LEN = 6;
    localparam int WATCHDOG = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd_i = 1'b0, vd_i = 1'b0;
    logic disp_en = 1'b1, size_h = 1'b0, size_v = 1'b0;
    logic [7:0] h_pos = '0, v_pos = '0;
    logic frame_en = 1'b0, bg_en = 1'b0, live_i = 1'b1, mute_i = 1'b0;
    logic [3:0] frm_y = '0, bg_y = '0, sw_dly = '0;
    logic [2:0] frm_u = '0, frm_v = '0, bg_u = '0, bg_v = '0;
    logic [7:0] sub_yaddr;
    logic [5:0] sub_caddr;
    logic [6:0] sub_line;
    logic [6:0] sub_y = '0, sub_u = '0, sub_v = '0;
    logic sub_cap_en, pip_sw;
    logic [6:0] pip_y, pip_u, pip_v;

    int n_cmp = 0, n_bad = 0;
    logic m_mute = 1'b0, m_live = 1'b1;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pip_overlay u0 (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .disp_en(disp_en),
        .size_h(size_h), .size_v(size_v), .h_pos(h_pos), .v_pos(v_pos),
        .frame_en(frame_en), .frm_y(frm_y), .frm_u(frm_u), .frm_v(frm_v),
        .bg_en(bg_en), .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
        .live_i(live_i), .mute_i(mute_i), .sw_dly(sw_dly),
        .sub_yaddr(sub_yaddr), .sub_caddr(sub_caddr), .sub_line(sub_line),
        .sub_y(sub_y), .sub_u(sub_u), .sub_v(sub_v), .sub_cap_en(sub_cap_en),
        .pip_sw(pip_sw), .pip_y(pip_y), .pip_u(pip_u), .pip_v(pip_v)
    );

    // Line buffer content as a function of inset line and column
    function automatic logic [6:0] buf_y(int ln, int col);
        return 7'((col * 3 + ln * 5) & 127);
    endfunction
    function automatic logic [6:0] buf_u(int ln, int col);
        return 7'((col * 7 + ln + 11) & 127);
    endfunction
    function automatic logic [6:0] buf_v(int ln, int col);
        return 7'((col * 13 + ln * 3 + 40) & 127);
    endfunction

    // Line buffer with one clock read latency
    always_ff @(posedge clk) begin
        sub_y <= buf_y(int'(sub_line), int'(sub_yaddr));
        sub_u <= buf_u(int'(sub_line), int'(sub_caddr));
        sub_v <= buf_v(int'(sub_line), int'(sub_caddr));
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected {sw, y, u, v} for pixel x of line y, and the requirement it exercises
    task automatic exp_px(input int x, input int y, output logic [21:0] e, output string tag);
        int x0, y0, w, h, b;
        x0 = int'(h_pos) * 4;
        y0 = int'(v_pos);
        w  = size_h ? 172 : 229;
        h  = size_v ? 52 : 69;
        b  = frame_en ? 2 : 0;
        if (!disp_en) begin
            e = '0; tag = "R9";
        end else if (x < x0 - b || x >= x0 + w + b || y < y0 - b || y >= y0 + h + b) begin
            e = '0; tag = "R3 R11";
        end else if (x < x0 || x >= x0 + w || y < y0 || y >= y0 + h) begin
            e = {1'b1, 7'(int'(frm_y) * 8), 7'(int'(frm_u) * 16), 7'(int'(frm_v) * 16)};
            tag = "R3 R4";
        end else if (bg_en) begin
            e = {1'b1, 7'(int'(bg_y) * 8), 7'(int'(bg_u) * 16), 7'(int'(bg_v) * 16)};
            tag = "R6";
        end else if (m_mute) begin
            e = {1'b1, 7'd0, 7'd64, 7'd64}; tag = "R7";
        end else begin
            e = {1'b1, buf_y(y - y0, x - x0), buf_u(y - y0, (x - x0) / 4),
                 buf_v(y - y0, (x - x0) / 4)};
            tag = "R3 R5";
        end
    endtask

    // One field: VD with the first HD, then lines; mute/live change at line 1
    task automatic run_field(input logic nxt_mute, input logic nxt_live);
        int nl;
        logic [21:0] e;
        string tag;
        nl = int'(v_pos) + (size_v ? 52 : 69) + 4;
        for (int j = 0; j < nl; j++) begin
            for (int k = 0; k < LINE_LEN; k++) begin
                @(negedge clk);
                if (j == 0 && k == 0) begin
                    m_mute = mute_i;
                    m_live = live_i;
                end
                if (j == 1 && k == 0) begin
                    mute_i = nxt_mute;
                    live_i = nxt_live;
                end
                if (k >= 4) begin
                    exp_px(k - 4, j, e, tag);
                    check({"R2 ", tag, " codes"}, int'({pip_y, pip_u, pip_v}), int'(e[20:0]));
                end
                if (k >= 4 + int'(sw_dly)) begin
                    exp_px(k - 4 - int'(sw_dly), j, e, tag);
                    check({"R10 ", tag, " switch"}, int'(pip_sw), int'(e[21]));
                end
                if (j == nl - 1 && k == 0)
                    check("R8 capture enable", int'(sub_cap_en), int'(m_live));
                hd_i = (k < HD_LEN);
                vd_i = (j == 0 && k < HD_LEN);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset switch", int'(pip_sw), 0);
        check("R1 reset codes", int'({pip_y, pip_u, pip_v}), 0);
        check("R1 reset capture", int'(sub_cap_en), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Field 1: top-left corner, large inset, border clipped by the edge
        disp_en = 1; size_h = 0; size_v = 0; h_pos = 0; v_pos = 0;
        frame_en = 1; frm_y = 4'd9; frm_u = 3'd5; frm_v = 3'd2; bg_en = 0; sw_dly = 0;
        run_field(1'b1, 1'b0);

        // Field 2: small inset, blanked, still, switch lag 5
        size_h = 1; size_v = 1; h_pos = 8'd10; v_pos = 8'd8; frame_en = 0; sw_dly = 4'd5;
        run_field(1'b1, 1'b0);

        // Field 3: fill wins over blanking, mixed scales, longest lag
        bg_en = 1; bg_y = 4'd13; bg_u = 3'd3; bg_v = 3'd6; frame_en = 1;
        size_h = 0; size_v = 1; h_pos = 8'd7; v_pos = 8'd3; sw_dly = 4'd15;
        run_field(1'b0, 1'b1);

        // Field 4: display off
        disp_en = 0; bg_en = 0; sw_dly = 0;
        run_field(1'b0, 1'b1);

        // Field 5: live picture, small width, lag 1
        disp_en = 1; size_h = 1; size_v = 0; frame_en = 1; h_pos = 8'd3; v_pos = 8'd2;
        sw_dly = 4'd1; frm_y = 4'd15; frm_u = 3'd7; frm_v = 3'd0;
        run_field(1'b0, 1'b1);

        // Random fields
        for (int f = 0; f < 2; f++) begin
            size_h   = 1'($urandom_range(0, 1));
            size_v   = 1'($urandom_range(0, 1));
            h_pos    = 8'($urandom_range(0, 10));
            v_pos    = 8'($urandom_range(0, 4));
            frame_en = 1'($urandom_range(0, 1));
            bg_en    = 1'($urandom_range(0, 1));
            mute_i   = 1'($urandom_range(0, 1));
            live_i   = 1'($urandom_range(0, 1));
            sw_dly   = 4'($urandom_range(0, 15));
            frm_y    = 4'($urandom_range(0, 15));
            frm_u    = 3'($urandom_range(0, 7));
            frm_v    = 3'($urandom_range(0, 7));
            bg_y     = 4'($urandom_range(0, 15));
            bg_u     = 3'($urandom_range(0, 7));
            bg_v     = 3'($urandom_range(0, 7));
            run_field(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule